// File: doc/BRIEF.md
# First-Error Priority Logger

This block records error events raised by a memory and system-bus controller. Each cycle it accepts a vector of error pulses. The first error to arrive is latched into a first-error register. Any error that arrives once that register is occupied is accumulated in a next-error register. Software reads both registers and clears them through a write-1-to-clear port. While the first-error register holds anything, an interrupt line is raised.

An in-order-queue depth tracker is built in. It counts bus requests (ADS strobes) against queue pops. It raises a queue error event on a pop to an empty queue, or on an ADS when the queue is already at its limit. The limit is 8, or 1 when the shallow-queue configuration bit is set.

The first-error register may hold only one ordinary bit. The correctable-memory bit is the single exception and may sit beside that ordinary bit. A correctable error that repeats while the correctable bit is still set is escalated to the non-fatal bit.

Both registers are sticky across the hard reset, which only empties the queue tracker. Only the power-on reset clears them.

The occupancy of the first-error register is tracked by a four-state machine. FE_EMPTY means nothing is held. FE_CORR means only the correctable bit is held. FE_HELD means only one ordinary bit is held. FE_BOTH means both are held. The transitions are:

- arrive_corr: a correctable event adds the correctable bit.
- arrive_nc: an ordinary event fills the single ordinary slot.
- clear_corr: a software clear of the correctable bit removes it.
- clear_nc: a software clear of the held ordinary bit removes it.

Several of these may occur in one cycle, and the next state follows from the resulting pair of held flags.

Top module: `errlog_ferr_top`

## Requirements
- R1: After power-on reset (por_n low), ferr_q and nerr_q are all zero, err_irq is low and the queue tracker is empty.
- R2: Hard reset (hrst_n low) leaves ferr_q and nerr_q unchanged and empties the queue tracker. With no event, no strobe and no clear, neither register changes.
- R3: With no ordinary bit held in ferr_q, a single ordinary event bit i (any bit except the correctable bit 8) sets ferr_q bit i on the next clock, and nerr_q is unchanged.
- R4: When several ordinary events arrive in one cycle with no ordinary bit held, the highest-numbered one is set in ferr_q and all the others are ORed into nerr_q.
- R5: While ferr_q holds an ordinary bit, new ordinary events are ORed into nerr_q and the ordinary part of ferr_q is unchanged. Occupancy is judged before any clear made in the same cycle.
- R6: ferr_q never holds more than one ordinary bit. A correctable event (bit 8) arriving while bit 8 of ferr_q is clear sets ferr_q bit 8 whether or not an ordinary bit is held.
- R7: A correctable event arriving while ferr_q bit 8 is already set is handled as a non-fatal event on bit 7. That event goes to ferr_q if no ordinary bit is held, and otherwise to nerr_q.
- R8: When clr_en is high, clr_sel selects ferr_q (0) or nerr_q (1). Each 1 in clr_data clears that bit, and each 0 leaves it unchanged. A bit set by an event in the same cycle stays set.
- R9: err_irq is high exactly when ferr_q is non-zero.
- R10: A pop_strobe while the queue is empty raises a queue error event on bit 2.
- R11: ADS increments and pop decrements the queue count. An ADS while the count equals the limit (8, or 1 when depth_one is 1) raises a queue error event on bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| hrst_n | input | 1 | Hard reset, active low, empties the queue tracker only |
| evt_in | input | 16 | Per-cycle error event pulses |
| ads_strobe | input | 1 | Bus request accepted into the in-order queue |
| pop_strobe | input | 1 | Entry retired from the in-order queue |
| depth_one | input | 1 | 1 selects a queue limit of 1, 0 a limit of 8 |
| clr_en | input | 1 | Write-1-to-clear strobe |
| clr_sel | input | 1 | 0 targets ferr_q, 1 targets nerr_q |
| clr_data | input | 16 | Bits to clear |
| ferr_q | output | 16 | First-error register |
| nerr_q | output | 16 | Next-error register |
| err_irq | output | 1 | Error interrupt, high while ferr_q is non-zero |

## Verification
A new error event and a software clear can land in the same cycle. The bench provokes this in two ways. First, it clears the held first-error bit exactly when a fresh ordinary event arrives, and expects the fresh event in nerr_q because occupancy is judged before the clear. Second, it clears an nerr_q bit in the cycle its event is raised again, and expects the bit to survive. A second coincidence is an ADS and a pop on the same edge against an empty queue: this must log an underflow, and the count must then stand at one. The bench judges the count through the later pops that do or do not raise bit 2.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    typedef enum logic [1:0] {
        FE_EMPTY = 2'd0,
        FE_CORR  = 2'd1,
        FE_HELD  = 2'd2,
        FE_BOTH  = 2'd3
    } fe_state_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_status_t;

endpackage

// File: rtl/errlog_ioq_track.sv
module errlog_ioq_track
    import errlog_pkg::*;
#(
    parameter int IOQ_DEPTH = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic hrst_n,
    input  logic ads_strobe,
    input  logic pop_strobe,
    input  logic depth_one,
    output logic ioq_err,
    output logic ioq_empty
);
    localparam int CW = $clog2(IOQ_DEPTH + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] limit;
    q_status_t     status;
    logic          inc;
    logic          dec;

    always_comb begin
        limit = depth_one ? CW'(1) : CW'(IOQ_DEPTH);
        if (cnt_q == '0) begin
            status = Q_EMPTY;
        end else if (cnt_q >= limit) begin
            status = Q_FULL;
        end else begin
            status = Q_PART;
        end
    end

    always_comb begin
        inc     = 1'b0;
        dec     = 1'b0;
        ioq_err = 1'b0;
        unique case (status)
            Q_EMPTY: begin
                inc     = ads_strobe;
                ioq_err = pop_strobe;
            end
            Q_PART: begin
                inc = ads_strobe;
                dec = pop_strobe;
            end
            Q_FULL: begin
                dec     = pop_strobe;
                ioq_err = ads_strobe;
            end
            default: begin
                inc = 1'b0;
            end
        endcase
        cnt_d = cnt_q;
        if (inc && !dec) begin
            cnt_d = cnt_q + CW'(1);
        end else if (dec && !inc) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!hrst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ioq_empty = (status == Q_EMPTY);

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int N_EVT        = 16,
    parameter int CORR_IDX     = 8,
    parameter int NONFATAL_IDX = 7
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [N_EVT-1:0] raw_evt,
    input  logic             clr_en,
    input  logic             clr_sel,
    input  logic [N_EVT-1:0] clr_data,
    output logic [N_EVT-1:0] ferr_q,
    output logic [N_EVT-1:0] nerr_q,
    output logic             held_any
);
    localparam logic [N_EVT-1:0] CORR_MASK = N_EVT'(1) << CORR_IDX;
    localparam logic [N_EVT-1:0] NF_MASK   = N_EVT'(1) << NONFATAL_IDX;

    fe_state_t        state_q;
    fe_state_t        state_d;
    logic             nc_held;
    logic             corr_held;
    logic [N_EVT-1:0] evt;
    logic [N_EVT-1:0] nc_evt;
    logic [N_EVT-1:0] win_vec;
    logic [N_EVT-1:0] ferr_set;
    logic [N_EVT-1:0] nerr_set;
    logic [N_EVT-1:0] ferr_clr;
    logic [N_EVT-1:0] nerr_clr;
    logic             clear_nc;
    logic             clear_corr;
    logic             nc_keep;
    logic             corr_keep;
    logic             nc_next;
    logic             corr_next;

    function automatic logic [N_EVT-1:0] top_bit(input logic [N_EVT-1:0] v);
        logic [N_EVT-1:0] r;
        r = '0;
        for (int k = 0; k < N_EVT; k++) begin
            if (v[k]) begin
                r    = '0;
                r[k] = 1'b1;
            end
        end
        return r;
    endfunction

    // occupancy decode of the current state
    always_comb begin
        nc_held   = 1'b0;
        corr_held = 1'b0;
        unique case (state_q)
            FE_EMPTY: begin
                nc_held   = 1'b0;
                corr_held = 1'b0;
            end
            FE_CORR: begin
                corr_held = 1'b1;
            end
            FE_HELD: begin
                nc_held = 1'b1;
            end
            FE_BOTH: begin
                nc_held   = 1'b1;
                corr_held = 1'b1;
            end
            default: begin
                nc_held = 1'b0;
            end
        endcase
    end

    // escalation of a repeated correctable error, then routing
    always_comb begin
        evt = raw_evt;
        if (corr_held && raw_evt[CORR_IDX]) begin
            evt = (raw_evt & ~CORR_MASK) | NF_MASK;
        end
        nc_evt  = evt & ~CORR_MASK;
        win_vec = top_bit(nc_evt);
        if (nc_held) begin
            ferr_set = evt & CORR_MASK;
            nerr_set = nc_evt;
        end else begin
            ferr_set = win_vec | (evt & CORR_MASK);
            nerr_set = nc_evt & ~win_vec;
        end
        ferr_clr = (clr_en && !clr_sel) ? clr_data : '0;
        nerr_clr = (clr_en &&  clr_sel) ? clr_data : '0;
    end

    assign clear_nc   = |(ferr_clr & ferr_q & ~CORR_MASK);
    assign clear_corr = ferr_clr[CORR_IDX];

    // next-state logic: the clear_nc / clear_corr transitions drop a held flag,
    // the arrive_nc / arrive_corr transitions raise one
    always_comb begin
        nc_keep   = 1'b0;
        corr_keep = 1'b0;
        unique case (state_q)
            FE_EMPTY: begin
                nc_keep   = 1'b0;
                corr_keep = 1'b0;
            end
            FE_CORR: begin
                corr_keep = !clear_corr;
            end
            FE_HELD: begin
                nc_keep = !clear_nc;
            end
            FE_BOTH: begin
                nc_keep   = !clear_nc;
                corr_keep = !clear_corr;
            end
            default: begin
                nc_keep = 1'b0;
            end
        endcase
        nc_next   = nc_keep || (|(ferr_set & ~CORR_MASK));
        corr_next = corr_keep || ferr_set[CORR_IDX];
        unique case ({nc_next, corr_next})
            2'b00:   state_d = FE_EMPTY;
            2'b01:   state_d = FE_CORR;
            2'b10:   state_d = FE_HELD;
            default: state_d = FE_BOTH;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= FE_EMPTY;
            ferr_q  <= '0;
            nerr_q  <= '0;
        end else begin
            state_q <= state_d;
            ferr_q  <= (ferr_q & ~ferr_clr) | ferr_set;
            nerr_q  <= (nerr_q & ~nerr_clr) | nerr_set;
        end
    end

    assign held_any = (state_q != FE_EMPTY);

endmodule

// File: rtl/errlog_ferr_top.sv
module errlog_ferr_top #(
    parameter int N_EVT        = 16,
    parameter int CORR_IDX     = 8,
    parameter int NONFATAL_IDX = 7,
    parameter int IOQ_IDX      = 2,
    parameter int IOQ_DEPTH    = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             hrst_n,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             ads_strobe,
    input  logic             pop_strobe,
    input  logic             depth_one,
    input  logic             clr_en,
    input  logic             clr_sel,
    input  logic [N_EVT-1:0] clr_data,
    output logic [N_EVT-1:0] ferr_q,
    output logic [N_EVT-1:0] nerr_q,
    output logic             err_irq
);
    localparam logic [N_EVT-1:0] IOQ_MASK = N_EVT'(1) << IOQ_IDX;

    logic             ioq_err;
    logic             ioq_empty;
    logic [N_EVT-1:0] raw_evt;

    errlog_ioq_track #(
        .IOQ_DEPTH (IOQ_DEPTH)
    ) u_ioq (
        .clk        (clk),
        .por_n      (por_n),
        .hrst_n     (hrst_n),
        .ads_strobe (ads_strobe),
        .pop_strobe (pop_strobe),
        .depth_one  (depth_one),
        .ioq_err    (ioq_err),
        .ioq_empty  (ioq_empty)
    );

    assign raw_evt = evt_in | (ioq_err ? IOQ_MASK : '0);

    errlog_capture #(
        .N_EVT        (N_EVT),
        .CORR_IDX     (CORR_IDX),
        .NONFATAL_IDX (NONFATAL_IDX)
    ) u_cap (
        .clk      (clk),
        .por_n    (por_n),
        .raw_evt  (raw_evt),
        .clr_en   (clr_en),
        .clr_sel  (clr_sel),
        .clr_data (clr_data),
        .ferr_q   (ferr_q),
        .nerr_q   (nerr_q),
        .held_any (err_irq)
    );

endmodule

// File: rtl/errlog_ferr_chk.sv
module errlog_ferr_chk #(
    parameter int N_EVT    = 16,
    parameter int CORR_IDX = 8,
    parameter int IOQ_IDX  = 2
) (
    input logic             clk,
    input logic             por_n,
    input logic [N_EVT-1:0] evt_in,
    input logic             ads_strobe,
    input logic             pop_strobe,
    input logic             clr_en,
    input logic             clr_sel,
    input logic [N_EVT-1:0] ferr_q,
    input logic [N_EVT-1:0] nerr_q,
    input logic             err_irq,
    input logic             ioq_empty
);
    localparam logic [N_EVT-1:0] NC_MASK = ~(N_EVT'(1) << CORR_IDX);

    assert_one_ordinary_R6: assert property (@(posedge clk) disable iff (!por_n)
        $countones(ferr_q & NC_MASK) <= 1);

    assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!por_n)
        err_irq == (ferr_q != '0));

    assert_ordinary_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        ((|(ferr_q & NC_MASK)) && !(clr_en && !clr_sel))
        |=> ((ferr_q & NC_MASK) == $past(ferr_q & NC_MASK)));

    assert_underflow_logged_R10: assert property (@(posedge clk) disable iff (!por_n)
        (pop_strobe && ioq_empty) |=> (ferr_q[IOQ_IDX] || nerr_q[IOQ_IDX]));

    assert_quiet_stable_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_en && evt_in == '0 && !ads_strobe && !pop_strobe)
        |=> ($stable(ferr_q) && $stable(nerr_q)));

endmodule

bind errlog_ferr_top errlog_ferr_chk #(
    .N_EVT    (N_EVT),
    .CORR_IDX (CORR_IDX),
    .IOQ_IDX  (IOQ_IDX)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .evt_in     (evt_in),
    .ads_strobe (ads_strobe),
    .pop_strobe (pop_strobe),
    .clr_en     (clr_en),
    .clr_sel    (clr_sel),
    .ferr_q     (ferr_q),
    .nerr_q     (nerr_q),
    .err_irq    (err_irq),
    .ioq_empty  (ioq_empty)
);

// File: tb/errlog_ferr_top_tb_top.sv
module errlog_ferr_top_tb_top;
    localparam int N = 16;
    localparam int CB = 8;
    localparam int NF = 7;
    localparam int QB = 2;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         hrst_n = 1'b0;
    logic [N-1:0] evt_in = '0;
    logic         ads_strobe = 1'b0;
    logic         pop_strobe = 1'b0;
    logic         depth_one = 1'b0;
    logic         clr_en = 1'b0;
    logic         clr_sel = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic [N-1:0] ferr_q;
    logic [N-1:0] nerr_q;
    logic         err_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    errlog_ferr_top dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .hrst_n     (hrst_n),
        .evt_in     (evt_in),
        .ads_strobe (ads_strobe),
        .pop_strobe (pop_strobe),
        .depth_one  (depth_one),
        .clr_en     (clr_en),
        .clr_sel    (clr_sel),
        .clr_data   (clr_data),
        .ferr_q     (ferr_q),
        .nerr_q     (nerr_q),
        .err_irq    (err_irq)
    );

    function automatic logic [N-1:0] b(input int i);
        return N'(1) << i;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] ef, input logic [N-1:0] en);
        n_cmp++;
        if (ferr_q !== ef || nerr_q !== en) begin
            n_bad++;
            $display("FAIL %s: ferr=%h nerr=%h expected ferr=%h nerr=%h", tag, ferr_q, nerr_q, ef, en);
        end
    endtask

    task automatic chk_irq(input string tag);
        n_cmp++;
        if (err_irq !== (ferr_q != '0)) begin
            n_bad++;
            $display("FAIL %s: err_irq=%b expected %b", tag, err_irq, (ferr_q != '0));
        end
    endtask

    task automatic pulse(input logic [N-1:0] v);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic clear_all();
        clr_en = 1'b1; clr_sel = 1'b0; clr_data = '1;
        @(negedge clk);
        clr_sel = 1'b1;
        @(negedge clk);
        clr_en = 1'b0; clr_data = '0;
    endtask

    task automatic wclr(input logic sel, input logic [N-1:0] d, input logic [N-1:0] v);
        clr_en = 1'b1; clr_sel = sel; clr_data = d; evt_in = v;
        @(negedge clk);
        clr_en = 1'b0; clr_data = '0; evt_in = '0;
    endtask

    task automatic ads(input int n);
        for (int k = 0; k < n; k++) begin
            ads_strobe = 1'b1;
            @(negedge clk);
            ads_strobe = 1'b0;
        end
    endtask

    task automatic pop(input int n);
        for (int k = 0; k < n; k++) begin
            pop_strobe = 1'b1;
            @(negedge clk);
            pop_strobe = 1'b0;
        end
    endtask

    task automatic hreset();
        hrst_n = 1'b0;
        @(negedge clk);
        hrst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        por_n = 1'b1; hrst_n = 1'b1;
        @(negedge clk);
        chk("R1 power-on state", '0, '0);
        chk_irq("R1 irq low");
        pop(1);
        chk("R1 queue empty after por", b(QB), '0);

        // R3 / R9: every single ordinary bit
        for (int i = 0; i < N; i++) begin
            if (i != CB) begin
                clear_all();
                chk_irq("R9 irq low after clear");
                pulse(b(i));
                chk("R3 single event", b(i), '0);
                chk_irq("R9 irq with ferr set");
            end
        end

        // R4: every pair of ordinary bits
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (i != CB && j != CB) begin
                    clear_all();
                    pulse(b(i) | b(j));
                    chk("R4 pair priority", b(j), b(i));
                end
            end
        end

        // R4: three at once
        clear_all();
        pulse(b(0) | b(5) | b(14));
        chk("R4 triple priority", b(14), b(0) | b(5));

        // R5
        clear_all();
        pulse(b(3));
        pulse(b(12));
        chk("R5 later event to nerr", b(3), b(12));
        pulse(b(15) | b(1));
        chk("R5 higher event still to nerr", b(3), b(12) | b(15) | b(1));

        // R6
        pulse(b(CB));
        chk("R6 corr beside ordinary", b(3) | b(CB), b(12) | b(15) | b(1));
        clear_all();
        pulse(b(CB));
        chk("R6 corr alone", b(CB), '0);
        pulse(b(5));
        chk("R6 corr leaves slot free", b(CB) | b(5), '0);
        clear_all();
        pulse(b(CB) | b(10));
        chk("R6 corr and ordinary together", b(CB) | b(10), '0);

        // R7
        clear_all();
        pulse(b(CB));
        pulse(b(CB));
        chk("R7 repeat corr escalates to ferr", b(CB) | b(NF), '0);
        pulse(b(CB));
        chk("R7 repeat corr escalates to nerr", b(CB) | b(NF), b(NF));

        // R8
        clear_all();
        pulse(b(3));
        pulse(b(12) | b(1));
        wclr(1'b1, b(12), '0);
        chk("R8 clear one nerr bit", b(3), b(1));
        wclr(1'b0, '0, '0);
        chk("R8 zero write keeps bits", b(3), b(1));
        wclr(1'b0, b(3), b(9));
        chk("R8 clear held bit with event same cycle", '0, b(1) | b(9));
        chk_irq("R9 irq after clear");
        pulse(b(4));
        wclr(1'b1, b(1), b(1));
        chk("R8 set wins over clear", b(4), b(1) | b(9));

        // R2: hard reset keeps registers, empties queue
        clear_all();
        pulse(b(6));
        ads(3);
        hreset();
        hreset();
        chk("R2 registers sticky through hard reset", b(6), '0);
        pop(1);
        chk("R2 queue emptied by hard reset", b(6), b(QB));
        repeat (4) @(negedge clk);
        chk("R2 quiet cycles change nothing", b(6), b(QB));

        // R10 / R11: balanced traffic at every fill level
        for (int n = 0; n <= 8; n++) begin
            hreset();
            clear_all();
            ads(n);
            pop(n);
            chk("R11 balanced traffic no error", '0, '0);
            pop(1);
            chk("R10 pop on empty", b(QB), '0);
        end

        // R11 overflow at 8
        hreset(); clear_all();
        ads(8);
        chk("R11 eight requests fit", '0, '0);
        ads(1);
        chk("R11 ninth request overflows", b(QB), '0);

        // R11 overflow at depth 1
        hreset(); clear_all();
        depth_one = 1'b1;
        ads(1);
        chk("R11 depth-one first request fits", '0, '0);
        ads(1);
        chk("R11 depth-one second request overflows", b(QB), '0);
        depth_one = 1'b0;

        // R10 / R11: ads and pop in the same cycle on an empty queue
        hreset(); clear_all();
        ads_strobe = 1'b1; pop_strobe = 1'b1;
        @(negedge clk);
        ads_strobe = 1'b0; pop_strobe = 1'b0;
        chk("R10 simultaneous ads and pop underflows", b(QB), '0);
        pop(1);
        chk("R11 count is one after simultaneous strobes", b(QB), '0);
        pop(1);
        chk("R10 second underflow to nerr", b(QB), b(QB));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule